// File: doc/BRIEF.md
# Chip-Select Programming Sequence Lock

This block keeps a flash programming sequence on one external chip-select free of other traffic. Requests arrive one at a time from several initiators. Each request carries a source ID, a chip-select index and a read/write flag. For each request the block returns accept or retry in the same cycle.

Only the data port can take a lock. It does so when it writes to a chip-select whose lock-enable bit is set. While the lock is held, every other initiator that targets the locked chip-select is told to retry. Requests to any other chip-select go through as normal. The lock is released in three ways:
- the data port reads the locked chip-select;
- the instruction port touches it, which also sets a sticky abort flag;
- a fail-safe countdown expires.

The countdown steps once per 16-clock prescaled tick. It reloads from a configured preload value each time a write completes.

Top module: `cs_seq_lock`

## Requirements
- R1: A data-port write (source ID 0) to a chip-select whose `cfg_lock_en` bit is clear never takes or moves a lock.
- R2: A data-port write to chip-select X with `cfg_lock_en[X]` set is accepted, and from the next cycle `lock_valid`=1 and `lock_cs`=X.
- R3: While locked, a valid request from source ID 2 or 3 to the locked chip-select gets `req_retry`=1 and `req_accept`=0. The same request to any other chip-select gets `req_accept`=1. With `req_valid`=0 both outputs are 0.
- R4: A data-port read of the locked chip-select is accepted and clears `lock_valid` from the next cycle. A data-port read of another chip-select leaves the lock unchanged.
- R5: A data-port write to a different lock-enabled chip-select Y while X is locked moves the lock to Y. At most one chip-select is locked.
- R6: An instruction-port request (source ID 1) to the locked chip-select is accepted, clears the lock and sets `abort_flag` from the next cycle. Instruction-port requests to other chip-selects change nothing.
- R7: `abort_flag` stays set until a cycle with `abort_clr`=1. If an abort and a clear fall in the same cycle, the set wins.
- R8: A prescale tick occurs on every 16th clock edge after reset release, that is edges 16, 32 and so on. With preload P, the lock is released at the (P+1)-th tick that comes strictly after the last reload edge.
- R9: The timer reloads on the lock-taking edge and on every edge where `wr_done`=1.
- R10: Reset clears the lock, the abort flag, the timer and the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_src | input | SRC_W | Source ID: 0 data port, 1 instruction port, others generic |
| req_cs | input | CS_W | Target chip-select index |
| req_wr | input | 1 | 1 for write, 0 for read |
| wr_done | input | 1 | A write has completed; reloads the timer |
| cfg_lock_en | input | NUM_CS | Per-chip-select lock enable |
| cfg_tmo_preload | input | TMO_W | Timer preload, in prescaled ticks |
| abort_clr | input | 1 | Write-1 clear of the abort flag |
| req_retry | output | 1 | Request must be retried |
| req_accept | output | 1 | Request accepted |
| lock_valid | output | 1 | A chip-select is locked |
| lock_cs | output | CS_W | Index of the locked chip-select |
| abort_flag | output | 1 | Sticky abort status |

## Verification
The hardest case to reach is a timeout release on an exact edge. The prescaler runs free and is not visible at the ports, so the bench counts edges from reset release itself. From the edge where the lock was taken, or where `wr_done` last reloaded the timer, it predicts the release edge. It then checks that the lock is still held one cycle before that edge and gone right after it, for preloads of 0 and 2 and with a reload in the middle of the countdown. Lock movement, retries and the abort are driven by a vector table, in one sequence with a single lock held across many requests.

// File: rtl/cs_lock_pkg.sv
package cs_lock_pkg;
  localparam int SRC_DATA = 0;
  localparam int SRC_INST = 1;

  typedef struct packed {
    logic retry;
    logic accept;
    logic take;
    logic rel_rd;
    logic abort;
  } lock_dec_t;
endpackage

// File: rtl/cs_lock_prescaler.sv
module cs_lock_prescaler #(
  parameter int PRESC = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int PW = $clog2(PRESC);

  logic [PW-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q == PW'(PRESC - 1));

  always_comb begin
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cs_lock_timer.sv
module cs_lock_timer #(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TMO_W-1:0] preload,
  input  logic             tick,
  input  logic             run,
  output logic             expire
);
  logic [TMO_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign expire = run && tick && (cnt_q == '0) && !load;
  assign cnt_en = load || (tick && (cnt_q != '0));

  always_comb begin
    if (load) cnt_d = preload;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cs_lock_decide.sv
module cs_lock_decide
  import cs_lock_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int SRC_W  = 2,
  localparam int CS_W  = $clog2(NUM_CS)
) (
  input  logic              req_valid,
  input  logic [SRC_W-1:0]  req_src,
  input  logic [CS_W-1:0]   req_cs,
  input  logic              req_wr,
  input  logic              lock_valid,
  input  logic [CS_W-1:0]   lock_cs,
  input  logic [NUM_CS-1:0] cfg_lock_en,
  output lock_dec_t         dec
);
  logic hit, from_data, from_inst;

  assign hit       = lock_valid && (req_cs == lock_cs);
  assign from_data = (req_src == SRC_W'(SRC_DATA));
  assign from_inst = (req_src == SRC_W'(SRC_INST));

  always_comb begin
    dec        = '0;
    dec.retry  = req_valid && hit && !from_data && !from_inst;
    dec.accept = req_valid && !dec.retry;
    if (req_valid && from_data) begin
      dec.take   = req_wr && cfg_lock_en[req_cs];
      dec.rel_rd = !req_wr && hit;
    end
    dec.abort = req_valid && from_inst && hit;
  end
endmodule

// File: rtl/cs_seq_lock.sv
module cs_seq_lock
  import cs_lock_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int SRC_W  = 2,
  parameter int TMO_W  = 8,
  parameter int PRESC  = 16,
  localparam int CS_W  = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [SRC_W-1:0]  req_src,
  input  logic [CS_W-1:0]   req_cs,
  input  logic              req_wr,
  input  logic              wr_done,
  input  logic [NUM_CS-1:0] cfg_lock_en,
  input  logic [TMO_W-1:0]  cfg_tmo_preload,
  input  logic              abort_clr,
  output logic              req_retry,
  output logic              req_accept,
  output logic              lock_valid,
  output logic [CS_W-1:0]   lock_cs,
  output logic              abort_flag
);
  lock_dec_t       dec;
  logic            pre_tick, tmo_expire;
  logic            lv_q, lv_d, ab_q, ab_d, lock_en;
  logic [CS_W-1:0] lcs_q, lcs_d;

  cs_lock_prescaler #(.PRESC(PRESC)) u_presc (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (pre_tick)
  );

  cs_lock_decide #(.NUM_CS(NUM_CS), .SRC_W(SRC_W)) u_dec (
    .req_valid  (req_valid),
    .req_src    (req_src),
    .req_cs     (req_cs),
    .req_wr     (req_wr),
    .lock_valid (lv_q),
    .lock_cs    (lcs_q),
    .cfg_lock_en(cfg_lock_en),
    .dec        (dec)
  );

  cs_lock_timer #(.TMO_W(TMO_W)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (dec.take || wr_done),
    .preload(cfg_tmo_preload),
    .tick   (pre_tick),
    .run    (lv_q),
    .expire (tmo_expire)
  );

  always_comb begin
    lv_d  = lv_q;
    lcs_d = lcs_q;
    if (dec.take) begin
      lv_d  = 1'b1;
      lcs_d = req_cs;
    end else if (dec.rel_rd || dec.abort || tmo_expire) begin
      lv_d = 1'b0;
    end
    ab_d = dec.abort ? 1'b1 : (abort_clr ? 1'b0 : ab_q);
  end

  assign lock_en = dec.take || dec.rel_rd || dec.abort || tmo_expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lv_q  <= 1'b0;
      lcs_q <= '0;
      ab_q  <= 1'b0;
    end else begin
      if (lock_en) begin
        lv_q  <= lv_d;
        lcs_q <= lcs_d;
      end
      ab_q <= ab_d;
    end
  end

  assign req_retry  = dec.retry;
  assign req_accept = dec.accept;
  assign lock_valid = lv_q;
  assign lock_cs    = lcs_q;
  assign abort_flag = ab_q;
endmodule

// File: rtl/cs_seq_lock_chk.sv
module cs_seq_lock_chk #(
  parameter int NUM_CS = 4,
  parameter int SRC_W  = 2,
  localparam int CS_W  = $clog2(NUM_CS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [SRC_W-1:0]  req_src,
  input logic [CS_W-1:0]   req_cs,
  input logic              req_wr,
  input logic [NUM_CS-1:0] cfg_lock_en,
  input logic              abort_clr,
  input logic              req_retry,
  input logic              req_accept,
  input logic              lock_valid,
  input logic [CS_W-1:0]   lock_cs,
  input logic              abort_flag,
  input logic              tick
);
  logic hit, d_rd_hit, i_hit;
  assign hit      = req_valid && lock_valid && (req_cs == lock_cs);
  assign d_rd_hit = hit && (req_src == SRC_W'(0)) && !req_wr;
  assign i_hit    = hit && (req_src == SRC_W'(1));

  // R3
  resp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_retry, req_accept}) && ((req_retry || req_accept) == req_valid));

  // R3
  retry_keeps_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_retry && !tick) |=> (lock_valid && $stable(lock_cs)));

  // R1
  lock_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_valid && (!$past(lock_valid) || !$stable(lock_cs))) |-> $past(cfg_lock_en[lock_cs]));

  // R4
  read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    d_rd_hit |=> !lock_valid);

  // R6
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    i_hit |=> (!lock_valid && abort_flag));

  // R7
  abort_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_flag && !abort_clr) |=> abort_flag);

  // R8
  release_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_valid) |-> ($past(tick) || $past(d_rd_hit) || $past(i_hit)));
endmodule

bind cs_seq_lock cs_seq_lock_chk #(.NUM_CS(NUM_CS), .SRC_W(SRC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_src(req_src),
  .req_cs(req_cs), .req_wr(req_wr), .cfg_lock_en(cfg_lock_en),
  .abort_clr(abort_clr), .req_retry(req_retry), .req_accept(req_accept),
  .lock_valid(lock_valid), .lock_cs(lock_cs), .abort_flag(abort_flag),
  .tick(pre_tick)
);

// File: tb/cs_seq_lock_bench.sv
module cs_seq_lock_bench;
  localparam int NUM_CS = 4;
  localparam int SRC_W  = 2;
  localparam int TMO_W  = 8;
  localparam int CS_W   = 2;
  localparam int NV     = 15;

  logic clk, rst_n;
  logic req_valid, req_wr, wr_done, abort_clr;
  logic [SRC_W-1:0] req_src;
  logic [CS_W-1:0]  req_cs;
  logic [NUM_CS-1:0] cfg_lock_en;
  logic [TMO_W-1:0]  cfg_tmo_preload;
  logic req_retry, req_accept, lock_valid, abort_flag;
  logic [CS_W-1:0] lock_cs;

  int n_chk, n_fail, ecnt;

  cs_seq_lock u_cs_seq_lock (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_src(req_src),
    .req_cs(req_cs), .req_wr(req_wr), .wr_done(wr_done),
    .cfg_lock_en(cfg_lock_en), .cfg_tmo_preload(cfg_tmo_preload),
    .abort_clr(abort_clr), .req_retry(req_retry), .req_accept(req_accept),
    .lock_valid(lock_valid), .lock_cs(lock_cs), .abort_flag(abort_flag)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) ecnt <= 0;
    else        ecnt <= ecnt + 1;

  // entry: src, cs, wr, exp_retry, exp_lock_valid, exp_lock_cs, exp_abort
  localparam logic [9:0] VEC [NV] = '{
    {2'd2, 2'd0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0}, // R3 no lock: accept
    {2'd0, 2'd1, 1'b1, 1'b0, 1'b1, 2'd1, 1'b0}, // R2 lock cs1
    {2'd2, 2'd1, 1'b0, 1'b1, 1'b1, 2'd1, 1'b0}, // R3 retry read
    {2'd3, 2'd1, 1'b1, 1'b1, 1'b1, 2'd1, 1'b0}, // R3 retry write
    {2'd2, 2'd0, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0}, // R3 other cs ok
    {2'd0, 2'd3, 1'b1, 1'b0, 1'b1, 2'd1, 1'b0}, // R1 disabled cs3
    {2'd0, 2'd0, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0}, // R4 read other cs
    {2'd0, 2'd2, 1'b1, 1'b0, 1'b1, 2'd2, 1'b0}, // R5 move to cs2
    {2'd2, 2'd1, 1'b0, 1'b0, 1'b1, 2'd2, 1'b0}, // R5 old cs free
    {2'd2, 2'd2, 1'b1, 1'b1, 1'b1, 2'd2, 1'b0}, // R5 new cs retried
    {2'd0, 2'd2, 1'b0, 1'b0, 1'b0, 2'd2, 1'b0}, // R4 read release
    {2'd2, 2'd2, 1'b1, 1'b0, 1'b0, 2'd2, 1'b0}, // R4 free after release
    {2'd0, 2'd0, 1'b1, 1'b0, 1'b1, 2'd0, 1'b0}, // R2 lock cs0
    {2'd1, 2'd1, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0}, // R6 inst other cs
    {2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1}  // R6 inst abort
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // starts and ends at a negedge
  task automatic issue(input int src, input int cs, input bit wr,
                       output bit rt, output bit ac);
    req_valid = 1'b1; req_src = SRC_W'(src); req_cs = CS_W'(cs); req_wr = wr;
    #1 rt = req_retry; ac = req_accept;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req_valid = 1'b0; req_src = '0; req_cs = '0; req_wr = 1'b0;
    wr_done = 1'b0; abort_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // release edge for preload p after a reload at edge e
  function automatic int rel_edge(input int e, input int p);
    return ((e / 16) + 1) * 16 + 16 * p;
  endfunction

  task automatic wait_release(input string req, input int rel);
    while (ecnt < rel - 1) @(negedge clk);
    chk({req, " held before release"}, lock_valid, 1);
    @(negedge clk);
    chk({req, " released on tick"}, lock_valid, 0);
  endtask

  initial begin : watchdog
    #3000000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit rt, ac;
    int e, p;
    n_chk = 0; n_fail = 0;
    cfg_lock_en = 4'b0111;
    cfg_tmo_preload = 8'd200;
    do_reset();

    // R10 reset state
    chk("R10 lock_valid", lock_valid, 0);
    chk("R10 abort_flag", abort_flag, 0);
    chk("R3 idle retry", req_retry, 0);
    chk("R3 idle accept", req_accept, 0);

    for (int i = 0; i < NV; i++) begin
      issue(int'(VEC[i][9:8]), int'(VEC[i][7:6]), VEC[i][5], rt, ac);
      chk($sformatf("R3 retry vec%0d", i), rt, VEC[i][4]);
      chk($sformatf("R3 accept vec%0d", i), ac, !VEC[i][4]);
      chk($sformatf("R5 lock_valid vec%0d", i), lock_valid, VEC[i][3]);
      if (VEC[i][3]) chk($sformatf("R5 lock_cs vec%0d", i), lock_cs, VEC[i][2:1]);
      chk($sformatf("R6 abort vec%0d", i), abort_flag, VEC[i][0]);
    end

    // R7 sticky, then write-1 clear
    repeat (3) @(negedge clk);
    chk("R7 sticky", abort_flag, 1);
    abort_clr = 1'b1; @(negedge clk); abort_clr = 1'b0;
    chk("R7 cleared", abort_flag, 0);

    // R7 set wins over clear in same cycle
    issue(0, 1, 1'b1, rt, ac);
    abort_clr = 1'b1;
    issue(1, 1, 1'b1, rt, ac);
    abort_clr = 1'b0;
    chk("R6 inst accepted on abort", ac, 1);
    chk("R7 set beats clear", abort_flag, 1);
    abort_clr = 1'b1; @(negedge clk); abort_clr = 1'b0;

    // R8 preload 0 timeout
    cfg_tmo_preload = 8'd0;
    issue(0, 2, 1'b1, rt, ac);
    e = ecnt;
    wait_release("R8 p0", rel_edge(e, 0));

    // R8 preload 2 timeout
    cfg_tmo_preload = 8'd2;
    issue(0, 0, 1'b1, rt, ac);
    e = ecnt;
    wait_release("R8 p2", rel_edge(e, 2));

    // R9 reload by wr_done mid countdown
    issue(0, 1, 1'b1, rt, ac);
    repeat (20) @(negedge clk);
    wr_done = 1'b1; @(negedge clk); wr_done = 1'b0;
    e = ecnt;
    p = 2;
    chk("R9 still held after reload", lock_valid, 1);
    wait_release("R9 reload", rel_edge(e, p));

    // R1 all disabled: no lock
    cfg_lock_en = 4'b0000;
    cfg_tmo_preload = 8'd200;
    issue(0, 0, 1'b1, rt, ac);
    chk("R1 disabled no lock", lock_valid, 0);
    issue(2, 0, 1'b1, rt, ac);
    chk("R1 other accepted", ac, 1);

    // R10 reset clears lock and abort
    cfg_lock_en = 4'b1111;
    issue(0, 3, 1'b1, rt, ac);
    chk("R2 lock cs3", lock_cs, 3);
    do_reset();
    chk("R10 lock cleared", lock_valid, 0);
    issue(2, 3, 1'b0, rt, ac);
    chk("R10 cs3 free after reset", ac, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule